// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block turns one PWM phase signal, produced by a motor-control timer, into a pair of complementary gate-drive levels: a high-side output and a low-side output. Whenever the phase changes, both outputs are held low for a programmable number of clock cycles before the newly active side is switched on. This gap prevents shoot-through in a half bridge. A three-phase bridge uses three instances.

The dead-time width is an 8-bit cycle count, captured when the run enable rises. A width of zero turns the gap off. A one-bit policy decides what happens when the phase toggles again before the dead-time count has finished. In restart mode the count goes back to zero for the new level. In reverse mode the counter turns around and counts back down, so the gap shrinks by itself and the previously active side comes back once the count reaches zero. The policy bit can only be written while the block is stopped. While the run enable is low, both outputs rest low.

All timing below is counted in rising clock edges. The edge that samples a phase change is edge 0.

Top module: `dtg_pair`

## Requirements
- R1: After reset both outputs are low, the policy is restart (policy bit value 0), and the captured width is 0.
- R2: `out_hi` and `out_lo` are never high in the same cycle.
- R3: When `run_en` is sampled low at an edge, both outputs are low after that edge and stay low while it remains low.
- R4: With width W > 0, a phase change sampled at edge 0 forces both outputs low after edge 0. The new side (`out_hi` for phase 1, `out_lo` for phase 0) goes high after edge W, provided the phase does not change again in between.
- R5: With width 0, the outputs follow the phase with one register of latency: after each edge `out_hi` equals the sampled phase and `out_lo` equals its complement.
- R6: In restart mode (policy bit 0), a phase change during the dead time restarts the count. The new side goes high W edges after the latest change.
- R7: In reverse mode (policy bit 1), a phase change after k counting edges (0 < k < W) reverses the counter. The previously active side goes high again k edges after that change.
- R8: In reverse mode, if the phase changes back at the very edge after the one that started the dead time (k = 0), the previously active side goes high immediately after that edge.
- R9: A policy write (`mode_we` with `mode_wdata`) is ignored while the block is running. It takes effect when made while stopped.
- R10: The width is captured from `dt_width` at the edge where `run_en` first reads high. Later changes to `dt_width` have no effect until the next start.
- R11: At start with W > 0, both outputs stay low after the start edge. The side chosen by the phase goes high after the W-th edge following it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; low holds both outputs low |
| phase | input | 1 | PWM phase from the carrier timer |
| dt_width | input | 8 | Dead-time width in clock cycles, captured at start |
| mode_wdata | input | 1 | Narrow-pulse policy: 0 restart, 1 reverse |
| mode_we | input | 1 | Write strobe for the policy bit, honoured only while stopped |
| out_hi | output | 1 | High-side gate drive |
| out_lo | output | 1 | Low-side gate drive |

## Verification
Two functions can fall on the same edge: completing or reversing a dead-time count, and a fresh phase change. The table of vectors provokes this by toggling the phase one and two edges into a dead time, in restart mode, so that the restart and the ongoing count meet. Directed tests do the same in reverse mode, at count 0 and at count 2. Each case is judged by the exact edge at which the correct side returns, which separates restart from reversal by several cycles. A policy write and a width change are also issued while running. The edge-exact return timing then shows that neither took effect.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int CNT_W = 8;

    typedef enum logic {
        NARROW_RESTART = 1'b0,
        NARROW_REVERSE = 1'b1
    } narrow_mode_e;

    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_dir_e;

    typedef struct packed {
        logic             tgt;   // phase level being served
        logic             busy;  // dead time in progress
        cnt_dir_e         dir;
        logic [CNT_W-1:0] cnt;
    } dt_state_t;

    localparam dt_state_t DT_IDLE = '{tgt: 1'b0, busy: 1'b0, dir: CNT_UP, cnt: '0};

    function automatic dt_state_t fresh_edge(input logic ph, input logic [CNT_W-1:0] w);
        dt_state_t s;
        s      = DT_IDLE;
        s.tgt  = ph;
        s.busy = (w != '0);
        return s;
    endfunction
endpackage

// File: rtl/dtg_cfg.sv
module dtg_cfg #(
    parameter int CNT_W = dtg_pkg::CNT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run_en,
    input  logic [CNT_W-1:0]       dt_width,
    input  logic                   mode_wdata,
    input  logic                   mode_we,
    output logic                   run_q,
    output logic                   start,
    output logic [CNT_W-1:0]       width_q,
    output logic [CNT_W-1:0]       width_eff,
    output dtg_pkg::narrow_mode_e  mode_q
);
    assign start     = run_en && !run_q;
    assign width_eff = start ? dt_width : width_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            width_q <= '0;
            mode_q  <= dtg_pkg::NARROW_RESTART;
        end else begin
            run_q <= run_en;
            if (start)
                width_q <= dt_width;
            if (mode_we && !run_q && !run_en)
                mode_q <= dtg_pkg::narrow_mode_e'(mode_wdata);
        end
    end
endmodule

// File: rtl/dtg_counter.sv
module dtg_counter #(
    parameter int CNT_W = dtg_pkg::CNT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_en,
    input  logic                  start,
    input  logic                  phase,
    input  logic [CNT_W-1:0]      width_eff,
    input  dtg_pkg::narrow_mode_e mode_q,
    output dtg_pkg::dt_state_t    st
);
    import dtg_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    dt_state_t nxt;
    logic      toggled;

    assign toggled = (phase != st.tgt);

    always_comb begin
        nxt = st;
        if (!run_en) begin
            nxt = DT_IDLE;
        end else if (start) begin
            nxt = fresh_edge(phase, width_eff);
        end else if (toggled) begin
            if (!st.busy || mode_q == NARROW_RESTART) begin
                nxt = fresh_edge(phase, width_eff);
            end else begin
                nxt.tgt = phase;
                if (st.dir == CNT_UP) begin
                    if (st.cnt == '0)
                        nxt.busy = 1'b0;
                    else
                        nxt.dir = CNT_DOWN;
                end else begin
                    nxt.dir = CNT_UP;
                end
            end
        end else if (st.busy) begin
            if (st.dir == CNT_UP) begin
                nxt.cnt = st.cnt + ONE;
                if (st.cnt + ONE == width_eff)
                    nxt.busy = 1'b0;
            end else begin
                nxt.cnt = st.cnt - ONE;
                if (st.cnt == ONE)
                    nxt.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= DT_IDLE;
        else
            st <= nxt;
    end
endmodule

// File: rtl/dtg_drive.sv
module dtg_drive (
    input  logic run_q,
    input  logic busy,
    input  logic tgt,
    output logic out_hi,
    output logic out_lo
);
    logic settled;

    assign settled = run_q && !busy;
    assign out_hi  = settled && tgt;
    assign out_lo  = settled && !tgt;
endmodule

// File: rtl/dtg_pair.sv
module dtg_pair #(
    parameter int CNT_W = dtg_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             phase,
    input  logic [CNT_W-1:0] dt_width,
    input  logic             mode_wdata,
    input  logic             mode_we,
    output logic             out_hi,
    output logic             out_lo
);
    logic                  run_q;
    logic                  start;
    logic [CNT_W-1:0]      width_q;
    logic [CNT_W-1:0]      width_eff;
    dtg_pkg::narrow_mode_e mode_q;
    dtg_pkg::dt_state_t    st;

    dtg_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .dt_width  (dt_width),
        .mode_wdata(mode_wdata),
        .mode_we   (mode_we),
        .run_q     (run_q),
        .start     (start),
        .width_q   (width_q),
        .width_eff (width_eff),
        .mode_q    (mode_q)
    );

    dtg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run_en   (run_en),
        .start    (start),
        .phase    (phase),
        .width_eff(width_eff),
        .mode_q   (mode_q),
        .st       (st)
    );

    dtg_drive u_drv (
        .run_q (run_q),
        .busy  (st.busy),
        .tgt   (st.tgt),
        .out_hi(out_hi),
        .out_lo(out_lo)
    );
endmodule

// File: rtl/dtg_pair_chk.sv
module dtg_pair_chk #(
    parameter int CNT_W = dtg_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic             phase,
    input logic             run_q,
    input logic [CNT_W-1:0] width_q,
    input logic             mode_bit,
    input logic             out_hi,
    input logic             out_lo
);
    a_r1_reset_low: assert property (@(posedge clk) rst |=> (!out_hi && !out_lo));

    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_hi && out_lo));

    a_r3_stopped_low: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!out_hi && !out_lo));

    // R4: with a nonzero width, a side turns on only after a cycle with the other side off
    a_r4_gap_hi: assert property (@(posedge clk) disable iff (rst)
        (width_q != '0 && $rose(out_hi)) |-> $past(!out_lo));

    a_r4_gap_lo: assert property (@(posedge clk) disable iff (rst)
        (width_q != '0 && $rose(out_lo)) |-> $past(!out_hi));

    a_r5_follow: assert property (@(posedge clk) disable iff (rst)
        (run_q && run_en && width_q == '0) |=> (out_hi == $past(phase) && out_lo == !$past(phase)));

    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q)) |-> $stable(mode_bit));

    a_r10_width_frozen: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q)) |-> $stable(width_q));
endmodule

bind dtg_pair dtg_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .phase   (phase),
    .run_q   (run_q),
    .width_q (width_q),
    .mode_bit(mode_q),
    .out_hi  (out_hi),
    .out_lo  (out_lo)
);

// File: tb/sim_dtg_pair.sv
module sim_dtg_pair;
    logic       clk = 1'b0;
    logic       rst;
    logic       run_en;
    logic       phase;
    logic [7:0] dt_width;
    logic       mode_wdata;
    logic       mode_we;
    logic       out_hi;
    logic       out_lo;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dtg_pair u0 (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .phase     (phase),
        .dt_width  (dt_width),
        .mode_wdata(mode_wdata),
        .mode_we   (mode_we),
        .out_hi    (out_hi),
        .out_lo    (out_lo)
    );

    // {phase driven before the edge, expected out_hi, expected out_lo after it}
    // restart mode, width 3, starting settled with the low side on (R4, R6)
    localparam logic [2:0] TBL [17] = '{
        3'b001, 3'b100, 3'b100, 3'b100, 3'b110, 3'b110,
        3'b000, 3'b100, 3'b100, 3'b100, 3'b110,
        3'b000, 3'b000, 3'b100, 3'b100, 3'b100, 3'b110
    };

    task automatic chk(input string req, input logic hi_e, input logic lo_e);
        checks++;
        if (out_hi !== hi_e || out_lo !== lo_e) begin
            errors++;
            $display("FAIL %s: hi/lo actual %b%b expected %b%b at %0t", req, out_hi, out_lo, hi_e, lo_e, $time);
        end
    endtask

    task automatic step(input logic ph);
        phase = ph;
        @(posedge clk);
        #1;
    endtask

    task automatic stop_run();
        run_en = 1'b0;
        step(phase);
    endtask

    task automatic set_mode(input logic m);
        mode_wdata = m;
        mode_we    = 1'b1;
        step(phase);
        mode_we    = 1'b0;
    endtask

    // start running with phase 0 and wait until the low side is on
    task automatic start_low(input logic [7:0] w);
        dt_width = w;
        run_en   = 1'b1;
        step(1'b0);
        for (int i = 0; i < w; i++) step(1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; run_en = 1'b0; phase = 1'b0; dt_width = 8'd0;
        mode_wdata = 1'b0; mode_we = 1'b0;
        #1;
        step(1'b0);
        step(1'b0);
        chk("R1 reset outputs", 1'b0, 1'b0);
        rst = 1'b0;
        step(1'b1);
        chk("R3 idle with phase high", 1'b0, 1'b0);

        // R11 startup dead time, width 3
        dt_width = 8'd3;
        run_en   = 1'b1;
        step(1'b0);
        chk("R11 after start edge", 1'b0, 1'b0);
        step(1'b0);
        step(1'b0);
        chk("R11 after edge 2", 1'b0, 1'b0);
        step(1'b0);
        chk("R11 after edge 3", 1'b0, 1'b1);

        // table walk: R4 and R6
        for (int i = 0; i < 17; i++) begin
            step(TBL[i][2]);
            chk($sformatf("R4/R6 vector %0d", i), TBL[i][1], TBL[i][0]);
        end

        // R3: stopping forces both low
        stop_run();
        chk("R3 after stop", 1'b0, 1'b0);
        step(1'b1);
        chk("R3 stays low", 1'b0, 1'b0);

        // R9: a write while running is ignored
        start_low(8'd3);
        chk("R9 setup low side on", 1'b0, 1'b1);
        set_mode(1'b1);
        step(1'b1);
        step(1'b1);
        step(1'b0);
        step(1'b0);
        chk("R9 policy still restart", 1'b0, 1'b0);
        step(1'b0);
        step(1'b0);
        chk("R9 restart completes", 1'b0, 1'b1);

        // R10: width change during run ignored
        dt_width = 8'd1;
        step(1'b1);
        step(1'b1);
        chk("R10 old width still used", 1'b0, 1'b0);
        step(1'b1);
        step(1'b1);
        chk("R10 width 3 completes", 1'b1, 1'b0);

        // R9 second half: a write while stopped takes effect
        stop_run();
        set_mode(1'b1);
        start_low(8'd4);
        chk("R7 setup low side on", 1'b0, 1'b1);

        // R8: immediate return at count 0
        step(1'b1);
        chk("R8 gap begins", 1'b0, 1'b0);
        step(1'b0);
        chk("R8 low side returns at once", 1'b0, 1'b1);

        // R7: reversal after 2 counting edges
        step(1'b1);
        step(1'b1);
        step(1'b1);
        step(1'b0);
        chk("R7 reversal edge", 1'b0, 1'b0);
        step(1'b0);
        chk("R7 one edge after reversal", 1'b0, 1'b0);
        step(1'b0);
        chk("R7 low side back after 2 edges", 1'b0, 1'b1);

        // R5: width zero follows the phase
        stop_run();
        dt_width = 8'd0;
        run_en   = 1'b1;
        step(1'b1);
        chk("R5 start follows phase", 1'b1, 1'b0);
        step(1'b0);
        chk("R5 follow low", 1'b0, 1'b1);
        step(1'b1);
        chk("R5 follow high", 1'b1, 1'b0);
        step(1'b0);
        chk("R5 follow low again", 1'b0, 1'b1);

        // R1: reset again mid-run clears policy and width
        rst = 1'b1;
        step(1'b1);
        chk("R1 reset mid-run", 1'b0, 1'b0);
        rst = 1'b0;
        run_en = 1'b0;
        step(1'b1);
        dt_width = 8'd2;
        start_low(8'd2);
        step(1'b1);
        step(1'b0);
        chk("R1 policy back to restart", 1'b0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule